// File: doc/BRIEF.md
# Four-Channel Dual-Address DMA Controller

This block moves data between two memory-mapped locations for up to four independent channels. Every unit it moves is a read at a source address followed by a write of the returned word to a destination address. A channel's source and destination can each advance by the unit size or stay fixed. A down-counter sets how many units the channel moves. When that counter runs out, the channel raises an end flag and an optional interrupt.

Software programs the block through a small word-addressed register port. Each channel owns four words: source, destination, count and control. One global word holds the master enable, two sticky fault flags and the arbitration mode. A channel can run on its own (free-running) or wait for a one-cycle request pulse from a peripheral, in which case each pulse buys exactly one unit. The bus is always handed back between units. Bus traffic goes out on a plain request/acknowledge memory handshake that carries an address, a size code, write data and an error response.

A fault seen during the read half of a unit does not cut the unit short. This applies to a non-maskable event input or to an error response from memory. The write still completes and the channel registers advance. The fault then holds off all further units until software clears its flag. Clearing the master enable is different: it abandons the unit in flight at once, on every channel, and leaves the end flags untouched.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low and every `irq` bit is low.
- R2: A unit is a read at the latched source address, then a write of the whole read word to the latched destination address with the same `mem_size`. The address holds while a request waits for `mem_ack`, and the write follows the read's acknowledge directly.
- R3: After each write acknowledge, the active channel's count drops by one. Its source and destination each advance by 1, 2 or 4 for size codes 0, 1 and 2 when their increment bit is set, and stay put otherwise.
- R4: When the count steps from 1 to 0, control bit 1 (end flag) sets. `irq[i]` is high while channel i has both its end flag and control bit 2 (interrupt enable) set.
- R5: A channel with a zero count, a set end flag or a clear control bit 0 (enable) starts no unit.
- R6: With control bit 7 clear, a channel moves exactly one unit per `dreq[i]` pulse. After each write acknowledge, `mem_req` drops for at least one cycle.
- R7: With global bit 3 clear, ready channels are served lowest index first.
- R8: With global bit 3 set, the channel served most recently gets the lowest rank. The search starts at the next higher index and wraps.
- R9: A pulse on `nmi` during a read lets that unit's write finish and update the registers. It sets global bit 1, and no unit starts until software clears that bit.
- R10: An error response on a read behaves the same way, except that it sets global bit 2.
- R11: Writing global bit 0 (master enable) to zero drops `mem_req` in the next cycle. The unit in flight is dropped with no write, its count and addresses are unchanged, no end flag sets, and no channel starts.
- R12: Channel i's registers sit at word 4i+0 (source), 4i+1 (destination), 4i+2 (count) and 4i+3 (control). The global word sits at 4·NCH. A write takes effect at the next clock and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| dreq | input | NCH | Per-channel peripheral request pulses |
| nmi | input | 1 | Non-maskable event pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for the write half of a unit |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Unit size code: 0 byte, 1 word, 2 longword |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes at this clock |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| irq | output | NCH | Per-channel end-of-transfer interrupt |

## Verification
The bench builds the block with its defaults: NCH=4, AW=32 and CW=16. Four channels put every fixed-priority rank and the round-robin wrap from channel 3 back to channel 0 within reach. A 16-bit count allows the 64-unit peripheral-paced run with a fixed source and an incrementing destination. Byte, word and longword units are each exercised. Faults are injected at the read half of a unit, and the master enable is cleared while an acknowledge is held back, so both kinds of stop are observed with their register side effects.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int CTRL_W = 8;
    localparam int GLB_W  = 4;

    // per-channel control word, bit 0 at the bottom
    typedef struct packed {
        logic       auto_req;  // 7: free-running, no peripheral pulse needed
        logic       dst_inc;   // 6
        logic       src_inc;   // 5
        logic [1:0] size;      // 4:3 unit size code
        logic       ie;        // 2 interrupt enable
        logic       te;        // 1 end flag
        logic       en;        // 0 channel enable
    } ch_ctrl_t;

    // global word
    typedef struct packed {
        logic rr;   // 3 round-robin arbitration
        logic ae;   // 2 address/bus error seen
        logic nmi;  // 1 non-maskable event seen
        logic men;  // 0 master enable
    } glb_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RD   = 2'd1,
        ENG_WR   = 2'd2
    } eng_state_e;

    function automatic logic [2:0] unit_step(input logic [1:0] size);
        case (size)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_field,
    input  logic [31:0]   wr_data,
    input  logic          unit_done,
    input  logic          take,
    input  logic          dreq,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output ch_ctrl_t      ctrl,
    output logic          pend
);

    logic [AW-1:0] step;
    assign step = AW'(unit_step(ctrl.size));

    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            ctrl <= '0;
            pend <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_field)
                    2'd0:    src  <= wr_data[AW-1:0];
                    2'd1:    dst  <= wr_data[AW-1:0];
                    2'd2:    cnt  <= wr_data[CW-1:0];
                    default: ctrl <= ch_ctrl_t'(wr_data[CTRL_W-1:0]);
                endcase
            end
            // completion of a unit overrides a colliding software write
            if (unit_done) begin
                if (ctrl.src_inc) src <= src + step;
                if (ctrl.dst_inc) dst <= dst + step;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) ctrl.te <= 1'b1;
            end
            pend <= ctrl.en & ((pend & ~take) | dreq);
        end
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic           rr,
    input  logic           take,
    output logic [NCH-1:0] grant,
    output logic [IW-1:0]  gidx,
    output logic           any
);

    logic [IW-1:0] last;

    always_comb begin
        int base;
        base  = rr ? ((int'(last) + 1) % NCH) : 0;
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            int idx;
            idx = (base + k) % NCH;
            if (!any && req[idx]) begin
                any        = 1'b1;
                gidx       = IW'(idx);
                grant[idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last <= IW'(NCH - 1);
        else if (take) last <= gidx;
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          men,
    input  logic          start,
    input  logic [IW-1:0] start_ch,
    input  logic [AW-1:0] start_src,
    input  logic [AW-1:0] start_dst,
    input  logic [1:0]    start_size,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    output logic          idle,
    output logic          unit_done,
    output logic [IW-1:0] done_ch,
    output logic          bus_err
);

    eng_state_e    state;
    logic [AW-1:0] src_q, dst_q;
    logic [1:0]    size_q;
    logic [31:0]   buf_q;
    logic [IW-1:0] ch_q;
    logic          acked;

    assign acked = men & mem_ack & (state != ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            size_q <= '0;
            buf_q  <= '0;
            ch_q   <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (start && men) begin
                    src_q  <= start_src;
                    dst_q  <= start_dst;
                    size_q <= start_size;
                    ch_q   <= start_ch;
                    state  <= ENG_RD;
                end
                ENG_RD: if (!men) begin
                    state <= ENG_IDLE;
                end else if (mem_ack) begin
                    buf_q <= mem_rdata;
                    state <= ENG_WR;  // faults never skip the write
                end
                ENG_WR: if (!men || mem_ack) state <= ENG_IDLE;
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign mem_req   = men & (state != ENG_IDLE);
    assign mem_we    = (state == ENG_WR);
    assign mem_addr  = (state == ENG_WR) ? dst_q : src_q;
    assign mem_size  = size_q;
    assign mem_wdata = buf_q;
    assign idle      = (state == ENG_IDLE);
    assign unit_done = acked & (state == ENG_WR);
    assign done_ch   = ch_q;
    assign bus_err   = acked & mem_err;

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int CW  = 16,
    localparam int IW       = $clog2(NCH),
    localparam int GLB_ADDR = 4 * NCH,
    localparam int RAW      = $clog2(GLB_ADDR + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic [NCH-1:0] dreq,
    input  logic           nmi,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ack,
    input  logic           mem_err,
    output logic [NCH-1:0] irq
);

    glb_t          glb;
    logic          g_men, g_blk;
    logic [AW-1:0] src_a [NCH];
    logic [AW-1:0] dst_a [NCH];
    logic [CW-1:0] cnt_a [NCH];
    ch_ctrl_t      ctrl_a[NCH];
    logic [NCH-1:0] pend, elig, grant;
    logic [IW-1:0] gidx, done_ch;
    logic          any, take, eng_idle, unit_done, bus_err;

    assign g_men = glb.men;
    assign g_blk = glb.nmi | glb.ae;

    always_ff @(posedge clk) begin
        if (rst) begin
            glb <= '0;
        end else begin
            if (reg_we && reg_addr == RAW'(GLB_ADDR))
                glb <= glb_t'(reg_wdata[GLB_W-1:0]);
            if (nmi)     glb.nmi <= 1'b1;
            if (bus_err) glb.ae  <= 1'b1;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_channel #(.AW(AW), .CW(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (reg_we && reg_addr[RAW-1:2] == (RAW-2)'(i)),
            .wr_field  (reg_addr[1:0]),
            .wr_data   (reg_wdata),
            .unit_done (unit_done && done_ch == IW'(i)),
            .take      (take && gidx == IW'(i)),
            .dreq      (dreq[i]),
            .src       (src_a[i]),
            .dst       (dst_a[i]),
            .cnt       (cnt_a[i]),
            .ctrl      (ctrl_a[i]),
            .pend      (pend[i])
        );
        assign elig[i] = g_men & ~g_blk & ctrl_a[i].en & ~ctrl_a[i].te
                       & (cnt_a[i] != '0) & (ctrl_a[i].auto_req | pend[i]);
        assign irq[i]  = ctrl_a[i].te & ctrl_a[i].ie;
    end

    dma_arbiter #(.NCH(NCH)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (elig),
        .rr    (glb.rr),
        .take  (take),
        .grant (grant),
        .gidx  (gidx),
        .any   (any)
    );

    assign take = eng_idle & any;

    dma_engine #(.AW(AW), .IW(IW)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .men        (g_men),
        .start      (take),
        .start_ch   (gidx),
        .start_src  (src_a[gidx]),
        .start_dst  (dst_a[gidx]),
        .start_size (ctrl_a[gidx].size),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_size   (mem_size),
        .mem_wdata  (mem_wdata),
        .idle       (eng_idle),
        .unit_done  (unit_done),
        .done_ch    (done_ch),
        .bus_err    (bus_err)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RAW'(GLB_ADDR)) begin
            reg_rdata = 32'(glb);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr[RAW-1:2] == (RAW-2)'(i)) begin
                    case (reg_addr[1:0])
                        2'd0:    reg_rdata = 32'(src_a[i]);
                        2'd1:    reg_rdata = 32'(dst_a[i]);
                        2'd2:    reg_rdata = 32'(cnt_a[i]);
                        default: reg_rdata = 32'(ctrl_a[i]);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
    parameter int AW  = 32,
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ack,
    input logic [AW-1:0]  mem_addr,
    input logic           men,
    input logic           blk,
    input logic           eng_idle,
    input logic [NCH-1:0] grant
);

    p_read_then_write_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> mem_we);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));

    p_bus_release_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> !mem_req);

    p_single_grant_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_fault_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (eng_idle && blk) |=> !mem_req);

    p_req_needs_enable_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> men);

endmodule

bind dma_ctrl dma_ctrl_chk #(.AW(AW), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .men      (g_men),
    .blk      (g_blk),
    .eng_idle (eng_idle),
    .grant    (grant)
);

// File: tb/tb_dma_ctrl.sv
`timescale 1ns/1ps
module tb_dma_ctrl;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  dreq = '0;
    logic        nmi = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [3:0]  irq;

    dma_ctrl dut (.*);

    always #2 clk = ~clk;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic [1:0]  s;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int rd_cnt = 0;
    int nmi_arm = 0, nmi_fired = 0, err_arm = 0, err_fired = 0;
    logic hold_ack = 1'b0;
    bit finished = 1'b0;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we && !hold_ack) begin
            mon_checks++;
            if (q.size() == 0) begin
                mon_errors++;
                $display("FAIL R2 unexpected write addr=%h data=%h (expected none)", mem_addr, mem_wdata);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (mem_addr !== e.a || mem_wdata !== e.d || mem_size !== e.s) begin
                    mon_errors++;
                    $display("FAIL R2 write addr=%h data=%h size=%0d expected addr=%h data=%h size=%0d",
                             mem_addr, mem_wdata, mem_size, e.a, e.d, e.s);
                end
            end
        end
        nmi = 1'b0;
        mem_err = 1'b0;
        if (!rst && mem_req && !mem_we && !hold_ack) begin
            rd_cnt++;
            if (nmi_arm > nmi_fired) begin nmi = 1'b1; nmi_fired++; end
            if (err_arm > err_fired) begin mem_err = 1'b1; err_fired++; end
        end
        mem_ack = mem_req && !hold_ack;
        mem_rdata = memval(mem_addr);
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic push_units(input logic [31:0] src, input logic [31:0] dst, input logic [1:0] sz,
                              input int n, input bit si, input bit di);
        int st;
        st = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.a = di ? dst + 32'(k * st) : dst;
            e.d = memval(si ? src + 32'(k * st) : src);
            e.s = sz;
            q.push_back(e);
        end
    endtask

    task automatic drain();
        int quiet;
        quiet = 0;
        for (int c = 0; c < 3000 && quiet < 4; c++) begin
            @(negedge clk); #1;
            if (q.size() == 0 && !mem_req) quiet++; else quiet = 0;
        end
        check(q.size() == 0, "R2 outstanding expected writes", 32'(q.size()), 0);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors",
                     checks + mon_checks + 1, errors + mon_errors + 1);
            $finish;
        end
    end

    initial begin
        int r0;
        wait_cyc(5);
        rst = 1'b0;

        // R1 / R12 reset state of the whole map
        for (int a = 0; a <= 16; a++) reg_chk(a, 32'h0, "R1 reset register");
        check(mem_req === 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
        check(irq === 4'b0, "R1 irq after reset", 32'(irq), 0);

        // R6/R3/R4 peripheral-paced byte run, fixed source, incrementing destination, 64 units on ch3
        reg_wr(16, 32'h1);
        reg_wr(12, 32'h0000_81A5);
        reg_wr(13, 32'h0000_0400);
        reg_wr(14, 32'd64);
        reg_chk(14, 32'd64, "R12 count readback");
        reg_wr(15, 32'h45);
        push_units(32'h81A5, 32'h400, 2'd0, 64, 1'b0, 1'b1);
        wait_cyc(10);
        check(rd_cnt == 0, "R6 no unit without request", 32'(rd_cnt), 0);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk); dreq[3] = 1'b1;
            @(negedge clk); dreq[3] = 1'b0;
            wait_cyc(8);
            if (k == 0) reg_chk(14, 32'd63, "R6 one unit per pulse");
        end
        drain();
        reg_chk(14, 32'd0, "R3 count exhausted");
        reg_chk(13, 32'h440, "R3 byte destination step");
        reg_chk(12, 32'h81A5, "R3 fixed source");
        reg_chk(15, 32'h47, "R4 end flag set");
        check(irq === 4'b1000, "R4 irq with enable", 32'(irq), 32'h8);
        r0 = rd_cnt;
        @(negedge clk); dreq[3] = 1'b1;
        @(negedge clk); dreq[3] = 1'b0;
        wait_cyc(10);
        check(rd_cnt == r0, "R5 ended channel ignores request", 32'(rd_cnt), 32'(r0));
        reg_wr(15, 32'h0);
        @(negedge clk); #1;
        check(irq === 4'b0, "R4 irq clears with flag", 32'(irq), 0);

        // R3 longword and word steps, free-running
        push_units(32'h1000, 32'h2000, 2'd2, 3, 1'b1, 1'b1);
        reg_wr(4, 32'h1000); reg_wr(5, 32'h2000); reg_wr(6, 32'd3);
        reg_wr(7, 32'hF1);
        drain();
        reg_chk(4, 32'h100C, "R3 longword source step");
        reg_chk(5, 32'h200C, "R3 longword destination step");
        check(irq === 4'b0, "R4 no irq without enable", 32'(irq), 0);
        push_units(32'h3000, 32'h3100, 2'd1, 2, 1'b1, 1'b0);
        reg_wr(8, 32'h3000); reg_wr(9, 32'h3100); reg_wr(10, 32'd2);
        reg_wr(11, 32'hA9);
        drain();
        reg_chk(8, 32'h3004, "R3 word source step");
        reg_chk(9, 32'h3100, "R3 fixed word destination");
        reg_wr(7, 32'h0); reg_wr(11, 32'h0);

        // R7 fixed priority: ch0 before ch2
        reg_wr(16, 32'h0);
        reg_wr(0, 32'h5000); reg_wr(1, 32'h6000); reg_wr(2, 32'd2); reg_wr(3, 32'hE1);
        reg_wr(8, 32'h7000); reg_wr(9, 32'h8000); reg_wr(10, 32'd2); reg_wr(11, 32'hE1);
        push_units(32'h5000, 32'h6000, 2'd0, 2, 1'b1, 1'b1);
        push_units(32'h7000, 32'h8000, 2'd0, 2, 1'b1, 1'b1);
        reg_wr(16, 32'h1);
        drain();
        reg_wr(3, 32'h0); reg_wr(11, 32'h0);

        // R8 round-robin: ch0 and ch1 alternate (last served was ch2)
        reg_wr(16, 32'h0);
        reg_wr(0, 32'h9000); reg_wr(1, 32'hA000); reg_wr(2, 32'd2); reg_wr(3, 32'hE1);
        reg_wr(4, 32'hB000); reg_wr(5, 32'hC000); reg_wr(6, 32'd2); reg_wr(7, 32'hE1);
        push_units(32'h9000, 32'hA000, 2'd0, 1, 1'b1, 1'b1);
        push_units(32'hB000, 32'hC000, 2'd0, 1, 1'b1, 1'b1);
        push_units(32'h9001, 32'hA001, 2'd0, 1, 1'b1, 1'b1);
        push_units(32'hB001, 32'hC001, 2'd0, 1, 1'b1, 1'b1);
        reg_wr(16, 32'h9);
        drain();
        reg_wr(3, 32'h0); reg_wr(7, 32'h0);
        reg_wr(16, 32'h1);

        // R5 zero count starts nothing
        r0 = rd_cnt;
        reg_wr(14, 32'd0); reg_wr(15, 32'h81);
        wait_cyc(20);
        check(rd_cnt == r0, "R5 zero count idle", 32'(rd_cnt), 32'(r0));
        reg_wr(15, 32'h0);

        // R9 nmi during the first read
        reg_wr(0, 32'hD000); reg_wr(1, 32'hE000); reg_wr(2, 32'd4);
        push_units(32'hD000, 32'hE000, 2'd0, 1, 1'b1, 1'b1);
        nmi_arm++;
        reg_wr(3, 32'hE1);
        drain();
        wait_cyc(10);
        reg_chk(2, 32'd3, "R9 count updated after write");
        reg_chk(0, 32'hD001, "R9 source updated");
        reg_chk(1, 32'hE001, "R9 destination updated");
        reg_chk(16, 32'h3, "R9 nmi flag set");
        reg_chk(3, 32'hE1, "R9 no end flag");
        push_units(32'hD001, 32'hE001, 2'd0, 3, 1'b1, 1'b1);
        reg_wr(16, 32'h1);
        drain();
        reg_chk(2, 32'd0, "R9 resumes after clear");
        reg_wr(3, 32'h0);

        // R10 error response on the first read
        reg_wr(4, 32'hF000); reg_wr(5, 32'hF800); reg_wr(6, 32'd3);
        push_units(32'hF000, 32'hF800, 2'd0, 1, 1'b1, 1'b1);
        err_arm++;
        reg_wr(7, 32'hE1);
        drain();
        wait_cyc(10);
        reg_chk(6, 32'd2, "R10 count updated after write");
        reg_chk(5, 32'hF801, "R10 destination updated");
        reg_chk(16, 32'h5, "R10 error flag set");
        reg_wr(7, 32'h0);
        reg_wr(16, 32'h1);

        // R11 master enable cleared with a read in flight
        reg_wr(16, 32'h0);
        reg_wr(0, 32'h100); reg_wr(1, 32'h200); reg_wr(2, 32'd5); reg_wr(3, 32'hE1);
        reg_wr(4, 32'h300); reg_wr(5, 32'h400); reg_wr(6, 32'd5); reg_wr(7, 32'hE1);
        hold_ack = 1'b1;
        reg_wr(16, 32'h1);
        wait_cyc(5);
        check(mem_req === 1'b1 && mem_we === 1'b0, "R11 read stalled before abort",
              {30'b0, mem_req, mem_we}, 32'h2);
        reg_wr(16, 32'h0);
        #1;
        check(mem_req === 1'b0, "R11 request dropped", 32'(mem_req), 0);
        wait_cyc(3);
        hold_ack = 1'b0;
        wait_cyc(20);
        check(mem_req === 1'b0, "R11 no channel starts", 32'(mem_req), 0);
        reg_chk(2, 32'd5, "R11 ch0 count unchanged");
        reg_chk(0, 32'h100, "R11 ch0 source unchanged");
        reg_chk(3, 32'hE1, "R11 ch0 no end flag");
        reg_chk(6, 32'd5, "R11 ch1 count unchanged");
        reg_chk(7, 32'hE1, "R11 ch1 no end flag");
        check(irq === 4'b0, "R11 no irq", 32'(irq), 0);
        check(q.size() == 0, "R11 no write issued", 32'(q.size()), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
        $finish;
    end

endmodule